// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Selector

This block holds the replacement state of a set-associative cache and names the way to evict. Each set owns a binary tree of single-bit nodes, with one node fewer than the number of ways. Each node remembers which half of its subtree holds the older lines. The number of ways is a power of two, eight by default. The tree records only a partial order, not a full ranking of the ways by age.

The cache presents one access per cycle: a set index and the way that was referenced. Hits and fills use the same port and update the tree in the same way, so no hit/fill indication is needed. The update is written on the next rising clock edge. A separate query port takes a set index and returns the victim way combinationally. The victim is found by walking the stored tree from the root down to a leaf. With two ways the tree reduces to one bit per set, and the policy becomes not-most-recently-used.

Top module: `plru_victim_sel`

## Requirements
- R1: The nodes of each set are kept in heap order: node 0 is the root, and node i has children 2i+1 (left, lower ways) and 2i+2 (right, higher ways). A node value of 0 means the left half is older, and 1 means the right half is older. `vicWay` is formed by starting at the root of set `vicSet` and taking the older half at each level, so the root decision is the most significant bit of the way.
- R2: While `rst` is high at a rising edge, every node of every set is cleared. Afterwards the victim of every set is way 0.
- R3: An access with `accValid` high sets each node on the path from the root to `accWay` in set `accSet` so that it points to the other half. The accessed way is never the victim immediately after its own access.
- R4: Nodes that are not on the accessed way's path keep their values. For example, in a fresh 8-way set, accessing way 0 and then way 4 gives victim way 2.
- R5: An access to one set leaves the victim of every other set unchanged.
- R6: An access is visible on the query port from the cycle after its clock edge. A query to the same set in the access cycle returns the victim from before the update.
- R7: After ways 0 to a-1 of a set are accessed in ascending order, that set's victim is way 0.
- R8: With `accValid` low, no set changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| accValid | input | 1 | A hit or fill is presented this cycle |
| accSet | input | $clog2(SETS) | Set index of the access |
| accWay | input | $clog2(WAYS) | Way referenced by the access |
| vicSet | input | $clog2(SETS) | Set index of the victim query |
| vicWay | output | $clog2(WAYS) | Way to evict from `vicSet` (combinational) |

## Verification
Directed sequences come first. An ascending sweep over all ways separates a correct path update from one that also disturbs nodes off the path. The two-access pattern (way 0, then way 4) shows whether the left subtree survives an update on the right. A query to the same set in the access cycle distinguishes a registered update from a write-through. Random traffic follows, with access and query set indices drawn from a small range so that collisions are frequent. Every query is compared with a bench tree model, which exposes a wrong polarity, a wrong heap index or a write to the wrong set.

// File: rtl/plru_pkg.sv
package plru_pkg;
  // strobes from control to the node store
  typedef struct packed {
    logic clear;  // wipe every set
    logic write;  // merge path bits into the addressed set
  } plruStrobe_t;
endpackage

// File: rtl/plru_ctrl.sv
module plru_ctrl
  import plru_pkg::*;
#(
  parameter int WAYS = 8,
  localparam int LVLS = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic             rst,
  input  logic             accValid,
  input  logic [LVLS-1:0]  accWay,
  output plruStrobe_t      strobe,
  output logic [NODES-1:0] nodeMask,
  output logic [NODES-1:0] nodeVal
);
  logic [LVLS-1:0] idx;

  always_comb begin
    strobe.clear = rst;
    strobe.write = accValid & ~rst;
  end

  // one node per level lies on the path; it is set to point away from accWay
  always_comb begin
    nodeMask = '0;
    nodeVal  = '0;
    idx      = '0;
    for (int l = 0; l < LVLS; l++) begin
      idx = LVLS'((1 << l) - 1) + LVLS'(accWay >> (LVLS - l));
      nodeMask[idx] = 1'b1;
      nodeVal[idx]  = ~accWay[LVLS-1-l];
    end
  end
endmodule

// File: rtl/plru_datapath.sv
module plru_datapath
  import plru_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 16,
  localparam int LVLS = $clog2(WAYS),
  localparam int NODES = WAYS - 1,
  localparam int SETW = $clog2(SETS)
) (
  input  logic             clk,
  input  plruStrobe_t      strobe,
  input  logic [SETW-1:0]  accSet,
  input  logic [NODES-1:0] nodeMask,
  input  logic [NODES-1:0] nodeVal,
  input  logic [SETW-1:0]  vicSet,
  output logic [LVLS-1:0]  vicWay
);
  logic [NODES-1:0] treeMem [SETS];
  logic [NODES-1:0] rowSel;
  logic [LVLS:0]    node;

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      for (int s = 0; s < SETS; s++) treeMem[s] <= '0;
    end else if (strobe.write) begin
      treeMem[accSet] <= (treeMem[accSet] & ~nodeMask) | (nodeVal & nodeMask);
    end
  end

  assign rowSel = treeMem[vicSet];

  // walk the older pointers from the root down to a leaf
  always_comb begin
    node   = '0;
    vicWay = '0;
    for (int l = 0; l < LVLS; l++) begin
      vicWay[LVLS-1-l] = rowSel[node[LVLS-1:0]];
      node = (node << 1) + (LVLS+1)'(1) + (LVLS+1)'(rowSel[node[LVLS-1:0]]);
    end
  end
endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel
  import plru_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 16,
  localparam int LVLS = $clog2(WAYS),
  localparam int NODES = WAYS - 1,
  localparam int SETW = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accValid,
  input  logic [SETW-1:0] accSet,
  input  logic [LVLS-1:0] accWay,
  input  logic [SETW-1:0] vicSet,
  output logic [LVLS-1:0] vicWay
);
  plruStrobe_t      strobe;
  logic [NODES-1:0] nodeMask;
  logic [NODES-1:0] nodeVal;

  plru_ctrl #(.WAYS(WAYS)) u_ctrl (
    .rst(rst), .accValid(accValid), .accWay(accWay),
    .strobe(strobe), .nodeMask(nodeMask), .nodeVal(nodeVal)
  );

  plru_datapath #(.WAYS(WAYS), .SETS(SETS)) u_dp (
    .clk(clk), .strobe(strobe), .accSet(accSet),
    .nodeMask(nodeMask), .nodeVal(nodeVal),
    .vicSet(vicSet), .vicWay(vicWay)
  );
endmodule

// File: rtl/plru_victim_sel_chk.sv
module plru_victim_sel_chk #(
  parameter int WAYS = 8,
  parameter int SETS = 16,
  localparam int LVLS = $clog2(WAYS),
  localparam int SETW = $clog2(SETS)
) (
  input logic            clk,
  input logic            rst,
  input logic            accValid,
  input logic [SETW-1:0] accSet,
  input logic [LVLS-1:0] accWay,
  input logic [SETW-1:0] vicSet,
  input logic [LVLS-1:0] vicWay
);
  logic seenReset = 1'b0;
  always_ff @(posedge clk) if (rst) seenReset <= 1'b1;

  // R2: the cycle after reset every set selects way 0
  a_r2_reset_way0: assert property (@(posedge clk) disable iff (rst || !seenReset)
    $fell(rst) |-> vicWay == '0);

  // R3: the way just referenced is not the next victim of its set
  a_r3_not_own_victim: assert property (@(posedge clk) disable iff (rst || !seenReset)
    accValid |=> (vicSet != $past(accSet) || vicWay != $past(accWay)));

  // R5 / R8: a set that was not written keeps its victim
  a_r5_other_set_stable: assert property (@(posedge clk) disable iff (rst || !seenReset)
    (!accValid || accSet != vicSet) |=> (vicSet != $past(vicSet) || $stable(vicWay)));

  // R1: the victim is always a defined way number
  a_r1_known_victim: assert property (@(posedge clk) disable iff (rst || !seenReset)
    !$isunknown(vicWay));
endmodule

bind plru_victim_sel plru_victim_sel_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (
  .clk(clk), .rst(rst), .accValid(accValid), .accSet(accSet),
  .accWay(accWay), .vicSet(vicSet), .vicWay(vicWay)
);

// File: tb/sim_plru_victim_sel.sv
`timescale 1ns/1ps
module sim_plru_victim_sel;
  localparam int WAYS = 8;
  localparam int SETS = 16;
  localparam int LVLS = $clog2(WAYS);
  localparam int NODES = WAYS - 1;
  localparam int SETW = $clog2(SETS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic accValid = 1'b0;
  logic [SETW-1:0] accSet = '0;
  logic [LVLS-1:0] accWay = '0;
  logic [SETW-1:0] vicSet = '0;
  logic [LVLS-1:0] vicWay;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic [NODES-1:0] mdl [SETS];

  always #2.5 clk = ~clk;

  plru_victim_sel #(.WAYS(WAYS), .SETS(SETS)) u0 (
    .clk(clk), .rst(rst), .accValid(accValid), .accSet(accSet),
    .accWay(accWay), .vicSet(vicSet), .vicWay(vicWay)
  );

  function automatic logic [LVLS-1:0] mdlVictim(input logic [NODES-1:0] t);
    int n = 0;
    logic [LVLS-1:0] w = '0;
    for (int l = 0; l < LVLS; l++) begin
      w[LVLS-1-l] = t[n];
      n = 2 * n + 1 + int'(t[n]);
    end
    return w;
  endfunction

  function automatic logic [NODES-1:0] mdlTouch(input logic [NODES-1:0] t,
                                                input logic [LVLS-1:0] w);
    logic [NODES-1:0] r = t;
    int n = 0;
    for (int l = 0; l < LVLS; l++) begin
      r[n] = ~w[LVLS-1-l];
      n = 2 * n + 1 + int'(w[LVLS-1-l]);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [LVLS-1:0] exp);
    nChecks++;
    if (vicWay !== exp) begin
      nFails++;
      $display("FAIL %s: set %0d victim %0d expected %0d", req, vicSet, vicWay, exp);
    end
  endtask

  // one cycle: drive at negedge, check the query before the edge, update model after it
  task automatic step(input bit v, input int s, input int w, input int q, input string req);
    @(negedge clk);
    accValid = v;
    accSet = SETW'(s);
    accWay = LVLS'(w);
    vicSet = SETW'(q);
    #1;
    check(req, mdlVictim(mdl[q]));
    @(posedge clk);
    if (v) mdl[s] = mdlTouch(mdl[s], LVLS'(w));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    for (int s = 0; s < SETS; s++) mdl[s] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R2: every set starts at way 0
    for (int s = 0; s < SETS; s++) step(1'b0, 0, 0, s, "R2");

    // R7: ascending sweep then victim 0; R3 per step
    for (int w = 0; w < WAYS; w++) step(1'b1, 3, w, 3, "R3");
    step(1'b0, 0, 0, 3, "R7");
    check("R7", '0);
    // R5: other set untouched
    step(1'b0, 0, 0, 4, "R5");
    check("R5", '0);

    // R4: way 0 then way 4 leaves left subtree, victim 2
    step(1'b1, 5, 0, 5, "R4");
    step(1'b1, 5, 4, 6, "R4");
    step(1'b0, 0, 0, 5, "R4");
    check("R4", LVLS'(2));

    // R6: same-cycle query sees old state (victim 0 while way 0 is accessed)
    step(1'b1, 7, 0, 7, "R6");
    step(1'b0, 0, 0, 7, "R6");
    check("R6", LVLS'(4));

    // R8: idle cycles hold state
    for (int i = 0; i < 4; i++) step(1'b0, 5, 7, 5, "R8");

    // R1: random traffic against the model, few sets to force collisions
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, int'($urandom % 4), int'($urandom % WAYS),
           int'($urandom % 4), "R1");

    // R2: reset again clears everything
    @(negedge clk);
    rst = 1'b1;
    accValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < SETS; s++) mdl[s] = '0;
    for (int s = 0; s < SETS; s++) step(1'b0, 0, 0, s, "R2");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule